// File: doc/BRIEF.md
# Port Pin Function Multiplexer

This block sits between a twelve-pin general-purpose I/O port and the on-chip peripherals that can borrow those pins. The port has two banks, an eight-pin bank A and a four-pin bank B. Pin indices 0 to 7 are A0 to A7, and indices 8 to 11 are B0 to B3. Every per-pin vector on the ports uses this order. For each pin the block decides whether the port's own data and direction registers drive the pad, or whether a peripheral output does. Where several functions share one pin, a fixed priority picks the winner. A global hold flag covers reset and external programming. While it is set, the pad drivers are forced off.

On the input side, the block produces a per-pin digital input-buffer enable. It then registers the gated pad values once. These synchronised values feed the port read-back and the pin-change interrupt sources. The block also routes pad inputs to the timer clock and capture inputs, the serial receiver, external interrupt 0 and the external clock input. A remap select moves the timer pins between two fixed location sets.

The block is combinational except for the single register stage on the synchronised inputs.

Top module: `pmx_top`

## Requirements
- R1: While `hold_io` is 1, `pad_oe` and `pad_out` are all zero, whatever the port registers and peripheral enables say.
- R2: Outside hold, `pad_oe[i]` is `gpio_dir[i]` OR'd with the enable of any peripheral output that owns pin i. A pin with no enabled owner outputs `gpio_out[i]`.
- R3: On pin 9 (B1) the output source priority is clock-out (`clko_en`), then serial clock (`xck_en`), then timer compare A (`oca_en`, only when `tmr_remap`=0), then the port register.
- R4: With `tmr_remap`=0, timer compare B drives pin 1 (A1) and compare A drives pin 9 (B1). `t0_in` is taken from pin 0 and `icp_in` from pin 10.
- R5: With `tmr_remap`=1, compare A drives pin 3, `icp_in` comes from pin 4, compare B drives pin 5 and `t0_in` comes from pin 11. Pins 1 and 9 then lose their timer outputs.
- R6: Serial transmit drives pin 10 and serial clock drives pin 9. `rxd_in` comes from pin 11. The comparator output drives pin 11 when `aco_en`=1.
- R7: `pad_ie[i]` is 1 unless `din_off[i]`=1 and `pcint_en[i]`=0, so an enabled pin-change source keeps the buffer on.
- R8: When `ext_clk_en`=1, `pad_ie[0]` is 1 regardless of `din_off[0]`, and `adc0_avail` is 0. `clki_in` follows `pad_in[0]` without delay; otherwise `clki_in` is 0.
- R9: Output enables never change `pad_ie`. With the comparator or compare B driving a pin, that pin's value still reaches `pin_sync`, `rxd_in` and `t0_in`.
- R10: `din_off` never affects `pad_oe` or `pad_out`. Serial transmit still drives pin 10 when `din_off[10]`=1.
- R11: `pin_sync` equals `pad_in & pad_ie` of the previous clock, so a disabled buffer reads 0. `int0_in` is `pin_sync[9]`.
- R12: While `rst_n` is 0, `pin_sync` is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the input register |
| rst_n | input | 1 | Active-low reset of the input register |
| hold_io | input | 1 | Reset/programming hold: all drivers off |
| gpio_out | input | 12 | Port data register per pin |
| gpio_dir | input | 12 | Port direction register per pin (1 = output) |
| din_off | input | 12 | Digital input-buffer disable request per pin |
| pcint_en | input | 12 | Pin-change interrupt enable per pin |
| tmr_remap | input | 1 | Selects the alternate timer pin set |
| ext_clk_en | input | 1 | External clock input enabled on pin 0 |
| clko_en | input | 1 | Clock output enable (pin 9) |
| clko_val | input | 1 | Clock output value |
| xck_en | input | 1 | Serial clock output enable (pin 9) |
| xck_val | input | 1 | Serial clock output value |
| oca_en | input | 1 | Timer compare A output enable |
| oca_val | input | 1 | Timer compare A value |
| ocb_en | input | 1 | Timer compare B output enable |
| ocb_val | input | 1 | Timer compare B value |
| txd_en | input | 1 | Serial transmit enable (pin 10) |
| txd_val | input | 1 | Serial transmit value |
| aco_en | input | 1 | Comparator output enable (pin 11) |
| aco_val | input | 1 | Comparator output value |
| pad_in | input | 12 | Raw pad input values |
| pad_out | output | 12 | Pad output values |
| pad_oe | output | 12 | Pad output-driver enables |
| pad_ie | output | 12 | Digital input-buffer enables |
| pin_sync | output | 12 | Registered gated pad values (port read, pin-change sources) |
| int0_in | output | 1 | External interrupt 0 input |
| t0_in | output | 1 | Timer clock input |
| icp_in | output | 1 | Timer capture input |
| rxd_in | output | 1 | Serial receive input |
| clki_in | output | 1 | External clock input |
| adc0_avail | output | 1 | Analog channel on pin 0 usable |

## Verification
The bench walks all eight combinations of the three pin-9 sources, in both remap settings. If the priority order is inverted, or compare A wins on pin 9 while remapped, pin 9 shows the wrong value. It sets input disables on pins that have pin-change enables or the external clock, and on the transmit pin. If a buffer override is dropped, `pin_sync` reads 0 where the pad was high. If the disable leaks into the drivers, the transmit pin goes silent. It also raises hold with every source enabled and moves the remap select under live pad traffic. A block that ignored hold would drive the pads. A stale location would feed `t0_in` or `icp_in` from the wrong pin.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

    typedef enum logic [2:0] {
        SRC_GPIO,
        SRC_CLKO,
        SRC_XCK,
        SRC_OCA,
        SRC_OCB,
        SRC_TXD,
        SRC_ACO
    } src_e;

    typedef struct packed {
        logic remap;
        logic clko;
        logic xck;
        logic oca;
        logic ocb;
        logic txd;
        logic aco;
    } periph_en_t;

    typedef struct packed {
        logic clko;
        logic xck;
        logic oca;
        logic ocb;
        logic txd;
        logic aco;
    } periph_val_t;

    // Owner of a pin's output; na is the bank A width, so bank B pin k is na+k.
    function automatic src_e pick_src(input int pin, input int na, input periph_en_t e);
        src_e s;
        s = SRC_GPIO;
        if (pin == na + 1) begin
            if (e.clko)                 s = SRC_CLKO;
            else if (e.xck)             s = SRC_XCK;
            else if (e.oca && !e.remap) s = SRC_OCA;
        end else if (pin == na + 2) begin
            if (e.txd) s = SRC_TXD;
        end else if (pin == na + 3) begin
            if (e.aco) s = SRC_ACO;
        end else if (pin == 1) begin
            if (e.ocb && !e.remap) s = SRC_OCB;
        end else if (pin == 3) begin
            if (e.oca && e.remap) s = SRC_OCA;
        end else if (pin == 5) begin
            if (e.ocb && e.remap) s = SRC_OCB;
        end
        return s;
    endfunction

endpackage

// File: rtl/pmx_drive.sv
module pmx_drive
    import pmx_pkg::*;
#(
    parameter int NA = 8,
    parameter int NB = 4,
    localparam int NP = NA + NB
) (
    input  logic           hold,
    input  logic [NP-1:0]  gpio_out,
    input  logic [NP-1:0]  gpio_dir,
    input  periph_en_t     en,
    input  periph_val_t    val,
    output logic [NP-1:0]  pad_out,
    output logic [NP-1:0]  pad_oe
);

    for (genvar p = 0; p < NP; p++) begin : g_pin
        src_e sel;
        logic drv;

        always_comb begin
            sel = pick_src(p, NA, en);
            unique case (sel)
                SRC_GPIO: drv = gpio_out[p];
                SRC_CLKO: drv = val.clko;
                SRC_XCK:  drv = val.xck;
                SRC_OCA:  drv = val.oca;
                SRC_OCB:  drv = val.ocb;
                SRC_TXD:  drv = val.txd;
                SRC_ACO:  drv = val.aco;
                default:  drv = gpio_out[p];
            endcase
        end

        assign pad_oe[p]  = ~hold & (gpio_dir[p] | (sel != SRC_GPIO));
        assign pad_out[p] = ~hold & drv;
    end

endmodule

// File: rtl/pmx_sense.sv
module pmx_sense #(
    parameter int NA = 8,
    parameter int NB = 4,
    localparam int NP  = NA + NB,
    localparam int PB1 = NA + 1,
    localparam int PB2 = NA + 2,
    localparam int PB3 = NA + 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NP-1:0]  pad_in,
    input  logic [NP-1:0]  din_off,
    input  logic [NP-1:0]  pcint_en,
    input  logic           ext_clk_en,
    input  logic           remap,
    output logic [NP-1:0]  pad_ie,
    output logic [NP-1:0]  pin_sync,
    output logic           int0_in,
    output logic           t0_in,
    output logic           icp_in,
    output logic           rxd_in,
    output logic           clki_in,
    output logic           adc0_avail
);

    for (genvar p = 0; p < NP; p++) begin : g_ie
        if (p == 0) begin : g_clk_pin
            assign pad_ie[p] = ~din_off[p] | pcint_en[p] | ext_clk_en;
        end else begin : g_plain
            assign pad_ie[p] = ~din_off[p] | pcint_en[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_sync <= '0;
        else        pin_sync <= pad_in & pad_ie;
    end

    assign int0_in    = pin_sync[PB1];
    assign t0_in      = remap ? pin_sync[PB3] : pin_sync[0];
    assign icp_in     = remap ? pin_sync[4]   : pin_sync[PB2];
    assign rxd_in     = pin_sync[PB3];
    assign clki_in    = ext_clk_en & pad_in[0];
    assign adc0_avail = ~ext_clk_en;

endmodule

// File: rtl/pmx_top.sv
module pmx_top
    import pmx_pkg::*;
#(
    parameter int NA = 8,
    parameter int NB = 4,
    localparam int NP = NA + NB
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold_io,
    input  logic [NP-1:0]  gpio_out,
    input  logic [NP-1:0]  gpio_dir,
    input  logic [NP-1:0]  din_off,
    input  logic [NP-1:0]  pcint_en,
    input  logic           tmr_remap,
    input  logic           ext_clk_en,
    input  logic           clko_en,
    input  logic           clko_val,
    input  logic           xck_en,
    input  logic           xck_val,
    input  logic           oca_en,
    input  logic           oca_val,
    input  logic           ocb_en,
    input  logic           ocb_val,
    input  logic           txd_en,
    input  logic           txd_val,
    input  logic           aco_en,
    input  logic           aco_val,
    input  logic [NP-1:0]  pad_in,
    output logic [NP-1:0]  pad_out,
    output logic [NP-1:0]  pad_oe,
    output logic [NP-1:0]  pad_ie,
    output logic [NP-1:0]  pin_sync,
    output logic           int0_in,
    output logic           t0_in,
    output logic           icp_in,
    output logic           rxd_in,
    output logic           clki_in,
    output logic           adc0_avail
);

    periph_en_t  en;
    periph_val_t val;

    assign en  = '{remap: tmr_remap, clko: clko_en, xck: xck_en, oca: oca_en,
                   ocb: ocb_en, txd: txd_en, aco: aco_en};
    assign val = '{clko: clko_val, xck: xck_val, oca: oca_val,
                   ocb: ocb_val, txd: txd_val, aco: aco_val};

    pmx_drive #(.NA(NA), .NB(NB)) i_drive (
        .hold     (hold_io),
        .gpio_out (gpio_out),
        .gpio_dir (gpio_dir),
        .en       (en),
        .val      (val),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    pmx_sense #(.NA(NA), .NB(NB)) i_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .pad_in     (pad_in),
        .din_off    (din_off),
        .pcint_en   (pcint_en),
        .ext_clk_en (ext_clk_en),
        .remap      (tmr_remap),
        .pad_ie     (pad_ie),
        .pin_sync   (pin_sync),
        .int0_in    (int0_in),
        .t0_in      (t0_in),
        .icp_in     (icp_in),
        .rxd_in     (rxd_in),
        .clki_in    (clki_in),
        .adc0_avail (adc0_avail)
    );

endmodule

// File: rtl/pmx_chk.sv
module pmx_chk #(
    parameter int NA = 8,
    parameter int NB = 4,
    localparam int NP  = NA + NB,
    localparam int PB1 = NA + 1,
    localparam int PB2 = NA + 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hold_io,
    input logic [NP-1:0]  pcint_en,
    input logic           ext_clk_en,
    input logic           clko_en,
    input logic           clko_val,
    input logic           txd_en,
    input logic [NP-1:0]  pad_in,
    input logic [NP-1:0]  pad_out,
    input logic [NP-1:0]  pad_oe,
    input logic [NP-1:0]  pad_ie,
    input logic [NP-1:0]  pin_sync,
    input logic           clki_in,
    input logic           adc0_avail
);

    a_r1_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hold_io |-> (pad_oe == '0 && pad_out == '0));

    a_r3_clko_first: assert property (@(posedge clk) disable iff (!rst_n)
        (clko_en && !hold_io) |-> (pad_oe[PB1] && pad_out[PB1] == clko_val));

    a_r7_pcint_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (|pcint_en) |-> ((pcint_en & ~pad_ie) == '0));

    a_r8_ext_clock: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clk_en |-> (pad_ie[0] && !adc0_avail && clki_in == pad_in[0]));

    a_r10_txd_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_en && !hold_io) |-> pad_oe[PB2]);

    a_r11_sync_stage: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pin_sync == $past(pad_in & pad_ie)));

    a_r12_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_sync == '0));

endmodule

bind pmx_top pmx_chk #(.NA(NA), .NB(NB)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_io    (hold_io),
    .pcint_en   (pcint_en),
    .ext_clk_en (ext_clk_en),
    .clko_en    (clko_en),
    .clko_val   (clko_val),
    .txd_en     (txd_en),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pad_ie     (pad_ie),
    .pin_sync   (pin_sync),
    .clki_in    (clki_in),
    .adc0_avail (adc0_avail)
);

// File: tb/test_pmx_top.sv
module test_pmx_top;

    localparam int CLK_P = 10;
    localparam int NP = 12;

    logic clk = 1'b0;
    always #(CLK_P / 2) clk = ~clk;

    logic rst_n, hold_io, tmr_remap, ext_clk_en;
    logic clko_en, clko_val, xck_en, xck_val, oca_en, oca_val;
    logic ocb_en, ocb_val, txd_en, txd_val, aco_en, aco_val;
    logic [NP-1:0] gpio_out, gpio_dir, din_off, pcint_en, pad_in;
    logic [NP-1:0] pad_out, pad_oe, pad_ie, pin_sync;
    logic int0_in, t0_in, icp_in, rxd_in, clki_in, adc0_avail;

    pmx_top i_pmx_top (
        .clk(clk), .rst_n(rst_n), .hold_io(hold_io),
        .gpio_out(gpio_out), .gpio_dir(gpio_dir), .din_off(din_off),
        .pcint_en(pcint_en), .tmr_remap(tmr_remap), .ext_clk_en(ext_clk_en),
        .clko_en(clko_en), .clko_val(clko_val), .xck_en(xck_en), .xck_val(xck_val),
        .oca_en(oca_en), .oca_val(oca_val), .ocb_en(ocb_en), .ocb_val(ocb_val),
        .txd_en(txd_en), .txd_val(txd_val), .aco_en(aco_en), .aco_val(aco_val),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
        .pin_sync(pin_sync), .int0_in(int0_in), .t0_in(t0_in), .icp_in(icp_in),
        .rxd_in(rxd_in), .clki_in(clki_in), .adc0_avail(adc0_avail)
    );

    int checks = 0;
    int errors = 0;
    string req = "R12";
    logic [NP-1:0] mq;

    task automatic check(input string what, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: who drives each pin, and which buffers stay on.
    function automatic void model(output logic [NP-1:0] oe, output logic [NP-1:0] out,
                                  output logic [NP-1:0] ie);
        for (int p = 0; p < NP; p++) begin
            bit taken = 0;
            bit v = gpio_out[p];
            if (p == 1 && ocb_en && !tmr_remap) begin taken = 1; v = ocb_val; end
            if (p == 3 && oca_en && tmr_remap)  begin taken = 1; v = oca_val; end
            if (p == 5 && ocb_en && tmr_remap)  begin taken = 1; v = ocb_val; end
            if (p == 9) begin
                if (clko_en)                      begin taken = 1; v = clko_val; end
                else if (xck_en)                  begin taken = 1; v = xck_val; end
                else if (oca_en && !tmr_remap)    begin taken = 1; v = oca_val; end
            end
            if (p == 10 && txd_en) begin taken = 1; v = txd_val; end
            if (p == 11 && aco_en) begin taken = 1; v = aco_val; end
            oe[p]  = !hold_io && (gpio_dir[p] || taken);
            out[p] = !hold_io && v;
            ie[p]  = !din_off[p] || pcint_en[p] || (p == 0 && ext_clk_en);
        end
    endfunction

    task automatic step();
        logic [NP-1:0] e_oe, e_out, e_ie;
        logic [5:0] misc, e_misc;
        @(posedge clk);
        model(e_oe, e_out, e_ie);
        if (!rst_n) mq = '0;
        else        mq = pad_in & e_ie;
        @(negedge clk);
        model(e_oe, e_out, e_ie);
        check("pad_oe", pad_oe, e_oe);
        check("pad_out", pad_out, e_out);
        check("pad_ie", pad_ie, e_ie);
        check("pin_sync", pin_sync, mq);
        misc   = {int0_in, t0_in, icp_in, rxd_in, clki_in, adc0_avail};
        e_misc = {mq[9], tmr_remap ? mq[11] : mq[0], tmr_remap ? mq[4] : mq[10],
                  mq[11], ext_clk_en & pad_in[0], !ext_clk_en};
        check("routed_inputs", {6'b0, misc}, {6'b0, e_misc});
    endtask

    task automatic clr();
        hold_io = 0; tmr_remap = 0; ext_clk_en = 0;
        {clko_en, clko_val, xck_en, xck_val, oca_en, oca_val} = '0;
        {ocb_en, ocb_val, txd_en, txd_val, aco_en, aco_val} = '0;
        gpio_out = '0; gpio_dir = '0; din_off = '0; pcint_en = '0; pad_in = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clr();
        rst_n = 0; hold_io = 1; pad_in = '1;
        mq = '0;
        req = "R12"; step(); step();
        rst_n = 1;

        req = "R1";
        gpio_dir = '1; gpio_out = '1;
        {clko_en, clko_val, xck_en, xck_val, oca_en, oca_val} = '1;
        {ocb_en, ocb_val, txd_en, txd_val, aco_en, aco_val} = '1;
        step(); tmr_remap = 1; step();
        clr();

        req = "R2";
        gpio_dir = 12'hA5C; gpio_out = 12'h3F0; step();
        gpio_dir = 12'h5A3; gpio_out = 12'hC0F; step();
        gpio_dir = 12'h000; gpio_out = 12'hFFF; step();
        gpio_dir = 12'hFFF; gpio_out = 12'h555; step();

        req = "R3";
        for (int r = 0; r < 2; r++) begin
            tmr_remap = r[0];
            for (int k = 0; k < 8; k++) begin
                {clko_en, xck_en, oca_en} = k[2:0];
                clko_val = 1; xck_val = 0; oca_val = 1; gpio_out[9] = 0; step();
                clko_val = 0; xck_val = 1; oca_val = 0; gpio_out[9] = 1; step();
            end
        end
        clr();

        req = "R4";
        oca_en = 1; ocb_en = 1; oca_val = 1; ocb_val = 1; gpio_out = 12'h028;
        pad_in = 12'h401; step();
        pad_in = 12'h810; step();
        req = "R5";
        tmr_remap = 1; oca_val = 0; gpio_out = 12'h202;
        pad_in = 12'h810; step();
        pad_in = 12'h401; step();
        oca_val = 1; ocb_val = 0; step();
        clr();

        req = "R6";
        txd_en = 1; txd_val = 1; xck_en = 1; xck_val = 1; aco_en = 1; aco_val = 1;
        pad_in = 12'h800; step();
        txd_val = 0; xck_val = 0; aco_val = 0; pad_in = 12'h000; step();
        clr();

        req = "R7";
        din_off = 12'hFFF; pcint_en = 12'h000; pad_in = 12'hFFF; step();
        pcint_en = 12'h9C3; step();
        din_off = 12'h0F0; pcint_en = 12'h030; step();
        clr();

        req = "R8";
        ext_clk_en = 1; din_off = 12'h001; pad_in = 12'h001; step();
        pad_in = 12'h000; step();
        ext_clk_en = 0; pad_in = 12'h001; step();
        clr();

        req = "R9";
        tmr_remap = 1; aco_en = 1; aco_val = 0; ocb_en = 1; ocb_val = 0;
        pad_in = 12'h820; step();
        pad_in = 12'h000; step();
        pad_in = 12'h820; tmr_remap = 0; ocb_val = 1; step();
        clr();

        req = "R10";
        din_off = 12'hFFF; txd_en = 1; txd_val = 1; gpio_dir = 12'h00F; gpio_out = 12'h00A; step();
        txd_val = 0; step();
        clr();

        req = "R11";
        din_off = 12'h0C3;
        pad_in = 12'hFFF; step();
        pad_in = 12'h200; step();
        pad_in = 12'h5A5; step();
        clr();

        req = "R12";
        pad_in = 12'hFFF; step();
        rst_n = 0; step();
        rst_n = 1; step();

        req = "R2";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            a = $urandom; b = $urandom;
            gpio_out = a[11:0]; gpio_dir = a[23:12]; pad_in = b[11:0];
            din_off = b[23:12]; pcint_en = {a[31:28], b[31:24]};
            {tmr_remap, ext_clk_en, clko_en, clko_val, xck_en, xck_val} = a[29:24];
            {oca_en, oca_val, ocb_en, ocb_val, txd_en, txd_val} = b[29:24];
            {aco_en, aco_val} = a[31:30];
            hold_io = (b[31:30] == 2'b11);
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule